// File: doc/BRIEF.md
# Multi-Device SPI Bus Master

This block drives one SPI bus shared by several peripherals. Each peripheral has its own select line. A client hands it one word per request over a valid/ready handshake. The request names the target device, a word length and the clock shape: idle level, sampling edge and rate. It also sets a settling delay after the select goes active, whether the select stays active once the word completes, and a number of clock periods to run afterwards with every select inactive. The block shifts the word out most significant bit first and samples the input line once per SCLK period. When the word ends it presents the received bits right-aligned, with a one-cycle done strobe.

A multi-word transaction is built by sending every word except the last with the hold flag set. The select then stays active between words, and later words of the transaction start without the settling delay. A request to any other device is refused until a word without the hold flag has released the select. There is no flow control from the peripheral side, so every transfer takes a fixed number of cycles whatever the input line carries.

Top module: `spi_multi_master`

## Requirements
- R1: On each SCLK period the block drives one bit on `mosi_o` and samples one bit of `miso_i`. Bits go out most significant first, the word returned on `rx_data_o` holds the sampled bits right-aligned with the first bit sampled in the highest used position, and the unused upper bits are zero.
- R2: The word length is the requested `req_len_i`. Values below 8 are treated as 8 and values above 16 as 16.
- R3: Only the addressed device's select is active. A select is active when `cs_o[d]` equals `cs_pol_i[d]` (1 means active-high, 0 active-low). Every other select sits at the opposite level.
- R4: Between transfers `sclk_o` rests at the idle level of the most recently accepted request, and at 0 after reset.
- R5: `req_fall_i`=0 samples on the rising SCLK edge and `req_fall_i`=1 on the falling edge. `mosi_o` changes only on the opposite edge, so it is stable at every sampling edge.
- R6: Every SCLK half-period lasts `req_div_i`+1 system clocks, including when `req_div_i` is 0.
- R7: A select becomes active in the cycle after the request is accepted. The first SCLK edge follows `req_lead_i`+`req_div_i`+1 system clocks later.
- R8: With `req_hold_i`=1 the select stays active after the word. While it is held, a request to a different device sees `req_ready_o` low, and a request to the same device starts shifting at once with no lead delay.
- R9: A word without the hold flag releases its select in the cycle its done strobe rises. `req_trail_i` full SCLK periods then follow with every select inactive and `mosi_o` high. Only after these does `req_ready_o` return.
- R10: `rx_valid_o` is a one-cycle pulse in the cycle after the last SCLK half-period ends. `req_ready_o` is low from acceptance until the block is idle again.
- R11: From the acceptance edge to the cycle in which `rx_valid_o` rises takes exactly lead + 2·len·(div+1) clocks, whatever `miso_i` does. The lead is 0 for a word that continues a held select.
- R12: After reset `sclk_o` is 0, `mosi_o` is 1, every select is inactive, `rx_valid_o` is 0 and `req_ready_o` is 1. `mosi_o` is 1 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge if valid |
| req_dev_i | input | DEV_W | Target device index |
| req_len_i | input | LEN_W | Word length in bits (clamped to 8..16) |
| req_cpol_i | input | 1 | SCLK idle level |
| req_fall_i | input | 1 | 1: sample on falling edge, 0: on rising edge |
| req_div_i | input | DIV_W | Half-period minus one, in system clocks |
| req_lead_i | input | LEAD_W | Clocks from select assertion to the start of shifting |
| req_hold_i | input | 1 | Keep the select active after this word |
| req_trail_i | input | TRAIL_W | SCLK periods to emit after release |
| req_data_i | input | MAX_BITS | Word to send, right-aligned |
| cs_pol_i | input | NUM_DEV | Per-device select polarity, 1 = active-high |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NUM_DEV | Device select lines |
| rx_valid_o | output | 1 | One-cycle done strobe |
| rx_data_o | output | MAX_BITS | Received word, right-aligned |

## Verification
A corrupted half-period or bit counter shows at once on `sclk_o` as a toggle in the wrong cycle. It also shifts the done strobe away from its fixed cycle count. A stale hold flag shows as a select that stays active after a releasing word, or as `req_ready_o` staying low for a different device, within one cycle of the done strobe. A wrong bit index shows on `mosi_o` in the half-period where that bit is due. A behavioural slave in the bench collects the bits at the chosen sampling edge and compares the whole word at every done strobe.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } spi_state_e;

endpackage

// File: rtl/spi_mm_divider.sv
module spi_mm_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == div_i);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_mm_bitsel.sv
module spi_mm_bitsel #(
    parameter int MAX_BITS = 16,
    parameter int LEN_W    = 5,
    parameter int HALF_W   = 9
) (
    input  logic                drive_i,
    input  logic                lead_smp_i,
    input  logic [HALF_W-1:0]   half_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [MAX_BITS-1:0] data_i,
    output logic                bit_o
);
    logic [HALF_W-1:0] k;
    logic [HALF_W-1:0] pos;

    always_comb begin
        if (lead_smp_i || (half_i == '0)) begin
            k = half_i >> 1;
        end else begin
            k = (half_i - HALF_W'(1)) >> 1;
        end
        pos   = HALF_W'(len_i) - HALF_W'(1) - k;
        bit_o = 1'b1;
        if (drive_i) begin
            for (int i = 0; i < MAX_BITS; i++) begin
                if (pos == HALF_W'(i)) begin
                    bit_o = data_i[i];
                end
            end
        end
    end
endmodule

// File: rtl/spi_mm_csdrv.sv
module spi_mm_csdrv #(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 2
) (
    input  logic               sel_on_i,
    input  logic [DEV_W-1:0]   sel_i,
    input  logic [NUM_DEV-1:0] pol_i,
    output logic [NUM_DEV-1:0] cs_o
);
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_cs
        assign cs_o[d] = (sel_on_i && (sel_i == DEV_W'(d))) ? pol_i[d] : ~pol_i[d];
    end
endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master
    import spi_mm_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int MIN_BITS = 8,
    parameter int MAX_BITS = 16,
    parameter int DIV_W    = 16,
    parameter int LEAD_W   = 8,
    parameter int TRAIL_W  = 8,
    localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_valid_i,
    output logic                req_ready_o,
    input  logic [DEV_W-1:0]    req_dev_i,
    input  logic [LEN_W-1:0]    req_len_i,
    input  logic                req_cpol_i,
    input  logic                req_fall_i,
    input  logic [DIV_W-1:0]    req_div_i,
    input  logic [LEAD_W-1:0]   req_lead_i,
    input  logic                req_hold_i,
    input  logic [TRAIL_W-1:0]  req_trail_i,
    input  logic [MAX_BITS-1:0] req_data_i,
    input  logic [NUM_DEV-1:0]  cs_pol_i,
    output logic                sclk_o,
    output logic                mosi_o,
    input  logic                miso_i,
    output logic [NUM_DEV-1:0]  cs_o,
    output logic                rx_valid_o,
    output logic [MAX_BITS-1:0] rx_data_o
);
    localparam int HB     = $clog2(2 * MAX_BITS + 1);
    localparam int HALF_W = (TRAIL_W + 1 > HB) ? TRAIL_W + 1 : HB;

    typedef struct packed {
        spi_state_e          st;
        logic [LEAD_W-1:0]   lcnt;
        logic [HALF_W-1:0]   half;
        logic [LEN_W-1:0]    len;
        logic                cpol;
        logic                lead_smp;
        logic                hold;
        logic [DIV_W-1:0]    div;
        logic [TRAIL_W-1:0]  trail;
        logic [DEV_W-1:0]    dev;
        logic                sel_on;
        logic                held;
        logic [MAX_BITS-1:0] tx;
        logic [MAX_BITS-1:0] rx;
        logic                rxv;
        logic [MAX_BITS-1:0] rxd;
    } regs_t;

    regs_t r_d, r_q;

    logic                accept;
    logic                tick;
    logic                run;
    logic                sample;
    logic [LEN_W-1:0]    len_in;
    logic [HALF_W-1:0]   shift_last;
    logic [HALF_W-1:0]   trail_last;
    logic [MAX_BITS-1:0] rx_shift;

    assign run = (r_q.st == ST_SHIFT) || (r_q.st == ST_TRAIL);

    spi_mm_divider #(.DIV_W(DIV_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .div_i  (r_q.div),
        .tick_o (tick)
    );

    spi_mm_bitsel #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .HALF_W(HALF_W)) u_bitsel (
        .drive_i    ((r_q.st == ST_LEAD) || (r_q.st == ST_SHIFT)),
        .lead_smp_i (r_q.lead_smp),
        .half_i     (r_q.half),
        .len_i      (r_q.len),
        .data_i     (r_q.tx),
        .bit_o      (mosi_o)
    );

    spi_mm_csdrv #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_cs (
        .sel_on_i (r_q.sel_on),
        .sel_i    (r_q.dev),
        .pol_i    (cs_pol_i),
        .cs_o     (cs_o)
    );

    always_comb begin
        if (req_len_i < LEN_W'(MIN_BITS)) begin
            len_in = LEN_W'(MIN_BITS);
        end else if (req_len_i > LEN_W'(MAX_BITS)) begin
            len_in = LEN_W'(MAX_BITS);
        end else begin
            len_in = req_len_i;
        end
    end

    always_comb begin
        req_ready_o = (r_q.st == ST_IDLE) && !(r_q.held && (req_dev_i != r_q.dev));
        accept      = req_valid_i && req_ready_o;
        shift_last  = HALF_W'({r_q.len, 1'b0}) - HALF_W'(1);
        trail_last  = HALF_W'({r_q.trail, 1'b0}) - HALF_W'(1);
        sample      = r_q.lead_smp ? ~r_q.half[0] : r_q.half[0];
        rx_shift    = sample ? {r_q.rx[MAX_BITS-2:0], miso_i} : r_q.rx;

        r_d     = r_q;
        r_d.rxv = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.len      = len_in;
                    r_d.cpol     = req_cpol_i;
                    r_d.lead_smp = (req_fall_i == req_cpol_i);
                    r_d.hold     = req_hold_i;
                    r_d.div      = req_div_i;
                    r_d.trail    = req_trail_i;
                    r_d.tx       = req_data_i;
                    r_d.rx       = '0;
                    r_d.half     = '0;
                    if (r_q.held) begin
                        r_d.st = ST_SHIFT;
                    end else begin
                        r_d.sel_on = 1'b1;
                        r_d.dev    = req_dev_i;
                        if (req_lead_i != '0) begin
                            r_d.st   = ST_LEAD;
                            r_d.lcnt = req_lead_i;
                        end else begin
                            r_d.st = ST_SHIFT;
                        end
                    end
                end
            end
            ST_LEAD: begin
                if (r_q.lcnt == LEAD_W'(1)) begin
                    r_d.st   = ST_SHIFT;
                    r_d.half = '0;
                end else begin
                    r_d.lcnt = r_q.lcnt - LEAD_W'(1);
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    r_d.rx = rx_shift;
                    if (r_q.half == shift_last) begin
                        r_d.rxv = 1'b1;
                        r_d.rxd = rx_shift;
                        if (r_q.hold) begin
                            r_d.held = 1'b1;
                            r_d.st   = ST_IDLE;
                        end else begin
                            r_d.held   = 1'b0;
                            r_d.sel_on = 1'b0;
                            r_d.half   = '0;
                            r_d.st     = (r_q.trail != '0) ? ST_TRAIL : ST_IDLE;
                        end
                    end else begin
                        r_d.half = r_q.half + HALF_W'(1);
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (r_q.half == trail_last) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.half = r_q.half + HALF_W'(1);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk_o     = run ? (r_q.cpol ^ r_q.half[0]) : r_q.cpol;
    assign rx_valid_o = r_q.rxv;
    assign rx_data_o  = r_q.rxd;

endmodule

// File: rtl/spi_mm_checker.sv
module spi_mm_checker #(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               req_valid_i,
    input logic               req_ready_o,
    input logic [DEV_W-1:0]   req_dev_i,
    input logic               sclk_o,
    input logic               mosi_o,
    input logic [NUM_DEV-1:0] cs_o,
    input logic [NUM_DEV-1:0] cs_pol_i,
    input logic               rx_valid_o
);
    logic [NUM_DEV-1:0] act;
    assign act = ~(cs_o ^ cs_pol_i);

    p_cs_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(act));

    p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |=> !rx_valid_o);

    p_mosi_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> mosi_o);

    p_stall_other_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((act != '0) && !act[req_dev_i]) |-> !req_ready_o);

    p_idle_clock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_ready_o && !req_valid_i) |=> $stable(sclk_o));

endmodule

bind spi_multi_master spi_mm_checker #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_dev_i   (req_dev_i),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .cs_o        (cs_o),
    .cs_pol_i    (cs_pol_i),
    .rx_valid_o  (rx_valid_o)
);

// File: tb/spi_multi_master_tb_top.sv
`timescale 1ns/1ps
module spi_multi_master_tb_top;
    localparam int ND = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_dev = '0;
    logic [4:0]  req_len = '0;
    logic        req_cpol = 1'b0;
    logic        req_fall = 1'b0;
    logic [15:0] req_div = '0;
    logic [7:0]  req_lead = '0;
    logic        req_hold = 1'b0;
    logic [7:0]  req_trail = '0;
    logic [15:0] req_data = '0;
    logic [3:0]  cs_pol = 4'b0101;
    logic        sclk, mosi, miso;
    logic [3:0]  cs;
    logic        rx_valid;
    logic [15:0] rx_data;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    spi_multi_master dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_dev_i(req_dev), .req_len_i(req_len),
        .req_cpol_i(req_cpol), .req_fall_i(req_fall),
        .req_div_i(req_div), .req_lead_i(req_lead),
        .req_hold_i(req_hold), .req_trail_i(req_trail),
        .req_data_i(req_data), .cs_pol_i(cs_pol),
        .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
        .cs_o(cs), .rx_valid_o(rx_valid), .rx_data_o(rx_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int clampl(input int l);
        return (l < 8) ? 8 : ((l > 16) ? 16 : l);
    endfunction

    // MISO pattern: free-running LFSR, unrelated to the bus
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso = lfsr[0];
    end

    // Behavioural reference model, advanced on every rising edge
    int m_st, m_lc, m_hc, m_h, m_len, m_div, m_trail, m_dev, m_sel;
    int m_tx, m_rx, m_rxd;
    bit m_cpol, m_lsmp, m_hold, m_held, m_rxv, m_sclk, m_mosi, m_acc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_sel = -1; m_cpol = 0; m_held = 0; m_rxv = 0; m_dev = 0;
            m_h = 0; m_hc = 0; m_lc = 0; m_len = 8; m_tx = 0; m_rx = 0; m_rxd = 0;
            m_div = 0; m_trail = 0; m_lsmp = 1; m_hold = 0;
        end else begin
            m_acc = req_valid && (m_st == 0) && !(m_held && int'(req_dev) != m_dev);
            m_rxv = 0;
            case (m_st)
                0: if (m_acc) begin
                    m_len = clampl(int'(req_len)); m_cpol = req_cpol;
                    m_lsmp = (req_fall == req_cpol); m_div = int'(req_div);
                    m_hold = req_hold; m_trail = int'(req_trail); m_tx = int'(req_data);
                    m_rx = 0; m_h = 0; m_hc = 0;
                    if (m_held) m_st = 2;
                    else begin
                        m_sel = int'(req_dev); m_dev = int'(req_dev);
                        if (req_lead > 0) begin m_st = 1; m_lc = int'(req_lead); end
                        else m_st = 2;
                    end
                end
                1: if (m_lc == 1) begin m_st = 2; m_h = 0; m_hc = 0; end
                   else m_lc--;
                2: if (m_hc == m_div) begin
                    if ((m_lsmp && m_h % 2 == 0) || (!m_lsmp && m_h % 2 == 1))
                        m_rx = ((m_rx << 1) | int'(miso)) & 'hFFFF;
                    m_hc = 0;
                    if (m_h == 2 * m_len - 1) begin
                        m_rxv = 1; m_rxd = m_rx;
                        if (m_hold) begin m_held = 1; m_st = 0; end
                        else begin
                            m_held = 0; m_sel = -1; m_h = 0;
                            m_st = (m_trail > 0) ? 3 : 0;
                        end
                    end else m_h++;
                end else m_hc++;
                3: if (m_hc == m_div) begin
                    m_hc = 0;
                    if (m_h == 2 * m_trail - 1) m_st = 0; else m_h++;
                end else m_hc++;
                default: m_st = 0;
            endcase
        end
        m_sclk = (m_st >= 2) ? (m_cpol ^ m_h[0]) : m_cpol;
        if (m_st == 1) m_mosi = m_tx[m_len-1];
        else if (m_st == 2) begin
            int k;
            k = (m_lsmp || m_h == 0) ? m_h / 2 : (m_h - 1) / 2;
            m_mosi = m_tx[m_len-1-k];
        end else m_mosi = 1;
    end

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit mrdy;
            logic [3:0] ecs;
            mrdy = (m_st == 0) && !(m_held && int'(req_dev) != m_dev);
            for (int d = 0; d < ND; d++) ecs[d] = (m_sel == d) ? cs_pol[d] : ~cs_pol[d];
            chk(req_ready == mrdy, "R10 ready", req_ready, mrdy);
            chk(sclk == m_sclk, "R6 sclk", sclk, m_sclk);
            chk(mosi == m_mosi, "R1 mosi", mosi, m_mosi);
            chk(cs == ecs, "R3 cs", cs, ecs);
            chk(rx_valid == m_rxv, "R10 rx_valid", rx_valid, m_rxv);
            if (m_rxv) chk(rx_data == 16'(m_rxd), "R1 rx_data", rx_data, m_rxd);
        end
    end

    // Behavioural slave and timing monitor
    int cur_len, cur_tx, cur_lead, cur_div;
    bit cur_fall;
    bit p_sclk = 0, p_mosi = 1, p_act = 0;
    int s_word = 0, s_cnt = 0;
    bit lwait = 0, hwait = 0;
    int lcnt = 0, hcnt = 0;

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit act;
            act = (~(cs ^ cs_pol)) != 4'b0;
            if (p_act && sclk != p_sclk && (cur_fall ? (p_sclk && !sclk) : (!p_sclk && sclk))) begin
                s_word = (s_word << 1) | int'(p_mosi);
                s_cnt++;
            end
            if (rx_valid) begin
                int mask;
                mask = (1 << cur_len) - 1;
                chk((s_word & mask) == (cur_tx & mask), "R5 slave word", s_word & mask, cur_tx & mask);
                chk(s_cnt == cur_len, "R2 bit count", s_cnt, cur_len);
                s_word = 0; s_cnt = 0;
            end
            if (!p_act && act) begin
                lwait = 1; lcnt = 0;
            end else if (lwait) begin
                lcnt++;
                if (sclk != p_sclk) begin
                    chk(lcnt == cur_lead + cur_div + 1, "R7 lead to first edge", lcnt, cur_lead + cur_div + 1);
                    lwait = 0; hwait = 1; hcnt = 0;
                end
            end else if (hwait) begin
                hcnt++;
                if (sclk != p_sclk) begin
                    chk(hcnt == cur_div + 1, "R6 half period", hcnt, cur_div + 1);
                    hwait = 0;
                end
            end
            p_act = act; p_sclk = sclk; p_mosi = mosi;
        end
    end

    bit tb_held = 0;

    task automatic xfer(input int dev, input int len, input bit cpol, input bit fall,
                        input int div, input int lead, input bit hold, input int trail,
                        input int data);
        int cyc, exp;
        @(negedge clk);
        req_dev = 2'(dev); req_len = 5'(len); req_cpol = cpol; req_fall = fall;
        req_div = 16'(div); req_lead = 8'(lead); req_hold = hold;
        req_trail = 8'(trail); req_data = 16'(data);
        cur_len = clampl(len); cur_tx = data & 'hFFFF; cur_lead = lead;
        cur_div = div; cur_fall = fall;
        req_valid = 1'b1;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rx_valid) begin
            @(negedge clk);
            cyc++;
        end
        exp = (tb_held ? 0 : lead) + 2 * cur_len * (div + 1) + 1;
        chk(cyc == exp, "R11 transfer length", cyc, exp);
        tb_held = hold;
    endtask

    task automatic trail_count(input int trail);
        int n;
        bit prev;
        n = 0; prev = sclk;
        while (!req_ready) begin
            @(negedge clk);
            #1;
            if (sclk != prev) n++;
            prev = sclk;
            chk(cs == ~cs_pol, "R9 selects inactive in trail", cs, ~cs_pol);
            chk(mosi == 1'b1, "R9 mosi high in trail", mosi, 1);
        end
        chk(n == 2 * trail, "R9 trailing edges", n, 2 * trail);
    endtask

    initial begin
        fork
            begin
                repeat (5) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk); #1;
                chk(sclk == 1'b0, "R12 reset sclk", sclk, 0);
                chk(mosi == 1'b1, "R12 reset mosi", mosi, 1);
                chk(cs == ~cs_pol, "R12 reset selects", cs, ~cs_pol);
                chk(rx_valid == 1'b0, "R12 reset rx_valid", rx_valid, 0);
                chk(req_ready == 1'b1, "R12 reset ready", req_ready, 1);

                xfer(0, 8, 0, 0, 0, 0, 0, 0, 'hA5);
                xfer(1, 16, 1, 1, 3, 5, 0, 0, 'hC3E1);
                repeat (6) begin
                    @(negedge clk); #1;
                    chk(sclk == 1'b1, "R4 idle level high", sclk, 1);
                end
                xfer(2, 12, 0, 1, 1, 2, 0, 0, 'h5A3);
                xfer(3, 10, 1, 0, 2, 0, 0, 0, 'h2CB);
                xfer(0, 5, 0, 0, 0, 1, 0, 0, 'h96);
                xfer(1, 20, 0, 1, 0, 3, 0, 0, 'hF00F);

                // held transaction and stall of another device
                xfer(2, 8, 0, 0, 1, 4, 1, 0, 'h3C);
                @(negedge clk);
                req_dev = 2'd3; req_hold = 1'b0; req_valid = 1'b1;
                repeat (20) begin
                    #1;
                    chk(req_ready == 1'b0, "R8 stall other device", req_ready, 0);
                    chk(cs[2] == cs_pol[2], "R8 select held", cs[2], cs_pol[2]);
                    @(negedge clk);
                end
                req_valid = 1'b0;
                xfer(2, 9, 0, 0, 1, 7, 1, 0, 'h1F0);
                xfer(2, 8, 0, 0, 0, 7, 0, 0, 'hE7);
                xfer(3, 8, 0, 0, 0, 2, 0, 0, 'h81);

                // trailing clocks
                xfer(0, 8, 0, 0, 2, 1, 0, 3, 'h55);
                trail_count(3);
                xfer(3, 11, 1, 1, 0, 0, 0, 1, 'h6A9);
                trail_count(1);

                for (int i = 0; i < 8; i++) begin
                    xfer(i % 4, 8 + i, bit'(i % 2), bit'((i / 2) % 2), i % 3, i % 4, 0, 0,
                         (i * 'h3B5) ^ 'h9C);
                end
                repeat (10) @(negedge clk);
            end
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule